// File: doc/BRIEF.md
# Latched Encoded Interrupt Status

This block turns two groups of level-sensitive interrupt lines into one compact status word. One group has 24 peripheral lines and the other has 17 main lines. For each group the block chooses one current interrupt and latches it. It reports that choice as a 6-bit encoded field in a 32-bit register. The top bit of each field is a presence flag and the lower five bits give the source index. A latched source stays current for as long as its line stays high, even if a more urgent line rises in the meantime. The block picks again by itself when the latched line falls. Software can also force a new choice by writing 1 to a group's flag bit.

One main line is the cascade line. It is high whenever the peripheral group is presenting an interrupt, so a handler that sees this main index reads the peripheral field next. Each group also drives a request output to the core. The register port is a simple read/write strobe pair with registered read data.

Top module: `enc_irq_status`

## Requirements
- R1: After synchronous reset, rd_data, per_req and main_req are all 0.
- R2: rd_data bits 29:24 hold the peripheral field, with its flag at bit 29 and its index at bits 28:24. Bits 21:16 hold the main field, with its flag at bit 21 and its index at bits 20:16. All other bits read 0. When peripheral source 0 is current, bits 29:24 read 0x20.
- R3: When a group evaluates, it latches the lowest-numbered asserted line with the flag set. If no line is asserted, the whole field becomes 0.
- R4: While the flag is set, the latched line stays high and no force write occurs, the field does not change, even if a lower-numbered line rises.
- R5: An idle group (flag 0) evaluates on every clock edge. On the first edge where its latched line is sampled low, the group evaluates again and the field takes the new choice at that same edge.
- R6: A write with wr_data bit 29 set forces the peripheral group to evaluate on that edge, even if its latched line is still high. A write with bit 21 set does the same for the main group.
- R7: Writing 0 to a flag bit, or writing any index or reserved bit, leaves both fields unchanged.
- R8: The effective main line 4 is main_irq[4] ORed with the registered peripheral flag.
- R9: per_req always equals the peripheral flag and main_req always equals the main flag.
- R10: rd_data is loaded on an edge where rd_en is high, and it holds otherwise. A read on the same edge as a forced evaluation returns the value from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| per_irq | input | 24 | Peripheral interrupt levels |
| main_irq | input | 17 | Main interrupt levels |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; bits 29 and 21 are force bits |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Registered status word |
| per_req | output | 1 | Peripheral group request |
| main_req | output | 1 | Main group request |

## Verification
The assertions assume that the interrupt lines and the strobes are synchronous to clk and only change between edges. They also assume that nothing about the lines is guaranteed, so every arrival order, including a lower-numbered line rising during a lock, must be handled. The bench drives all inputs on the falling edge. It mixes directed sequences for lock, release, force and cascade with a long run of random line levels, random force writes and random reads. A behavioural model is compared with the outputs on every cycle.

// File: rtl/enc_irq_pkg.sv
package enc_irq_pkg;
  localparam int FIELD_W  = 6;
  localparam int IDX_W    = FIELD_W - 1;
  localparam int REG_W    = 32;
  localparam int PER_LSB  = 24;
  localparam int MAIN_LSB = 16;
  localparam int PER_FLAG_BIT  = PER_LSB + FIELD_W - 1;
  localparam int MAIN_FLAG_BIT = MAIN_LSB + FIELD_W - 1;

  typedef struct packed {
    logic             flag;
    logic [IDX_W-1:0] idx;
  } enc_field_t;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic [N-1:0]  lines,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |lines;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lines[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_grp_latch.sv
module irq_grp_latch
  import enc_irq_pkg::*;
#(
  parameter int N = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [N-1:0] lines,
  input  logic        force_eval,
  output enc_field_t  field
);
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic             held_hi;
  logic             eval;

  prio_pick #(.N(N), .IW(IDX_W)) u_pick (
    .lines(lines), .any(pick_any), .idx(pick_idx)
  );

  assign held_hi = lines[field.idx];
  assign eval    = !field.flag || force_eval || !held_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      field <= '0;
    end else if (eval) begin
      field.flag <= pick_any;
      field.idx  <= pick_any ? pick_idx : '0;
    end
  end

  // R4: a held line without a force keeps the field
  a_r4_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (field.flag && lines[field.idx] && !force_eval) |=> $stable(field));
  // R3: an empty field has index 0
  a_r3_empty_zero: assert property (@(posedge clk) disable iff (rst)
    !field.flag |-> (field.idx == '0));
  // R3: evaluation with no line asserted clears the flag
  a_r3_none_clears: assert property (@(posedge clk) disable iff (rst)
    (eval && lines == '0) |=> !field.flag);
  // R6: forced evaluation with line 0 high selects index 0
  a_r6_force_pick0: assert property (@(posedge clk) disable iff (rst)
    (force_eval && lines[0]) |=> (field.flag && field.idx == '0));
endmodule

// File: rtl/enc_irq_status.sv
module enc_irq_status
  import enc_irq_pkg::*;
#(
  parameter int PER_N     = 24,
  parameter int MAIN_N    = 17,
  parameter int CASC_IDX  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PER_N-1:0]  per_irq,
  input  logic [MAIN_N-1:0] main_irq,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rd_data,
  output logic              per_req,
  output logic              main_req
);
  enc_field_t        per_f, main_f;
  logic [MAIN_N-1:0] main_eff;
  logic [REG_W-1:0]  status_word;

  always_comb begin
    main_eff = main_irq;
    main_eff[CASC_IDX] = main_irq[CASC_IDX] | per_f.flag;
  end

  irq_grp_latch #(.N(PER_N)) u_per (
    .clk(clk), .rst(rst), .lines(per_irq),
    .force_eval(wr_en & wr_data[PER_FLAG_BIT]), .field(per_f)
  );

  irq_grp_latch #(.N(MAIN_N)) u_main (
    .clk(clk), .rst(rst), .lines(main_eff),
    .force_eval(wr_en & wr_data[MAIN_FLAG_BIT]), .field(main_f)
  );

  always_comb begin
    status_word = '0;
    status_word[PER_LSB +: FIELD_W]  = per_f;
    status_word[MAIN_LSB +: FIELD_W] = main_f;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= status_word;
  end

  assign per_req  = per_f.flag;
  assign main_req = main_f.flag;

  // R8: a presented peripheral interrupt makes the main group present one
  a_r8_cascade: assert property (@(posedge clk) disable iff (rst)
    per_req |=> main_req);
  // R2: reserved bits of the read word stay 0
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~(32'h3F << PER_LSB | 32'h3F << MAIN_LSB)) == '0);
  // R10: read data holds without a read strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tb_enc_irq_status.sv
module tb_enc_irq_status;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [23:0] per_irq = '0;
  logic [16:0] main_irq = '0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic per_req, main_req;

  int checks = 0, errors = 0;

  // behavioural model state
  bit m_pf, m_mf;
  int m_pi, m_mi;
  logic [31:0] m_rd;

  enc_irq_status dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lowest(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] word(bit pf, int pi, bit mf, int mi);
    logic [31:0] w = '0;
    w[29] = pf; w[28:24] = 5'(pi);
    w[21] = mf; w[20:16] = 5'(mi);
    return w;
  endfunction

  always @(posedge clk) begin
    bit opf, omf; int opi, omi, p; logic [31:0] ml;
    if (rst) begin
      m_pf = 0; m_mf = 0; m_pi = 0; m_mi = 0; m_rd = '0;
    end else begin
      opf = m_pf; opi = m_pi; omf = m_mf; omi = m_mi;
      if (rd_en) m_rd = word(opf, opi, omf, omi);
      if (!opf || (wr_en && wr_data[29]) || !per_irq[opi]) begin
        p = lowest(32'(per_irq), 24);
        m_pf = (p >= 0); m_pi = (p >= 0) ? p : 0;
      end
      ml = 32'(main_irq);
      ml[4] = ml[4] | opf;
      if (!omf || (wr_en && wr_data[21]) || !ml[omi]) begin
        p = lowest(ml, 17);
        m_mf = (p >= 0); m_mi = (p >= 0) ? p : 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R9, R10)
  always @(negedge clk) begin
    if (!rst) begin
      chk(rd_data === m_rd, "R10", rd_data, m_rd);
      chk(per_req === m_pf, "R9", 32'(per_req), 32'(m_pf));
      chk(main_req === m_mf, "R9", 32'(main_req), 32'(m_mf));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3); rst = 0; idle(1);
    chk(rd_data == 0 && !per_req && !main_req, "R1", rd_data, 0);

    per_irq = 24'h000220; idle(3); rd(v);           // lines 5 and 9
    chk(v == word(1,5,1,4), "R3/R8", v, word(1,5,1,4));

    per_irq = 24'h000224; idle(3); rd(v);           // line 2 rises: lock
    chk(v == word(1,5,1,4), "R4", v, word(1,5,1,4));

    per_irq = 24'h000204; @(negedge clk); @(negedge clk);
    chk(per_req, "R5", 32'(per_req), 1);
    rd(v);
    chk(v == word(1,2,1,4), "R5", v, word(1,2,1,4));

    per_irq = 24'h000205; idle(2);                  // line 0 rises while 2 held
    @(negedge clk); wr_en = 1; wr_data = 32'h2000_0000; rd_en = 1;
    @(negedge clk); wr_en = 0; wr_data = '0; rd_en = 0;
    chk(rd_data == word(1,2,1,4), "R10", rd_data, word(1,2,1,4));
    rd(v);
    chk(v[29:24] == 6'h20, "R2/R6", 32'(v[29:24]), 32'h20);

    wr(32'hDFDF_FFFF); rd(v);                       // flags 0, all else 1
    chk(v == word(1,0,1,4), "R7", v, word(1,0,1,4));

    main_irq = 17'h00002; idle(3); rd(v);
    chk(v == word(1,0,1,4), "R4", v, word(1,0,1,4));
    wr(32'h0020_0000); rd(v);
    chk(v == word(1,0,1,1), "R6", v, word(1,0,1,1));

    per_irq = '0; idle(3); rd(v);
    chk(v == word(0,0,1,1), "R3", v, word(0,0,1,1));
    main_irq = 17'h00010; idle(3); rd(v);           // raw line 4 alone
    chk(v == word(0,0,1,4), "R8", v, word(0,0,1,4));
    main_irq = '0; idle(3); rd(v);
    chk(v == 0, "R3", v, 0);

    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) per_irq = 24'($urandom) & 24'($urandom);
      if ($urandom_range(0, 7) == 0) main_irq = 17'($urandom) & 17'($urandom);
      wr_en = ($urandom_range(0, 9) == 0);
      wr_data = $urandom;
      rd_en = $urandom_range(0, 1);
    end
    @(negedge clk); wr_en = 0; rd_en = 0;
    idle(2);
    rst = 1; idle(2);
    chk(rd_data == 0 && !per_req && !main_req, "R1", rd_data, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule